// File: doc/BRIEF.md
# Banked Memory Mapper with Boot ROM Overlay

This block sits between the 16-bit memory bus of an 8-bit processor and two synchronous arrays: a 64 KB RAM and a 2 KB boot ROM. For every bus access it chooses one target: the ROM, the RAM, or no target at all. It drives the chip selects and address of the chosen array. It returns read data one cycle after the request and drops writes that must not land anywhere.

Three control values set the routing. Each is loaded by an I/O-port write. A boot-overlay flag maps the ROM image over the lower 32 KB and repeats it every 2 KB. A 3-bit bank number, when non-zero, disconnects storage: reads return 0xFF and writes vanish. A common-window enable keeps the top of the space (above 0xE000) wired to RAM whatever the bank. Reset turns the overlay on, so the processor fetches its first instructions from ROM. The arrays themselves sit outside the block. Their read data returns on `ram_rdata` and `rom_rdata` in the cycle after a select.

Top module: `mem_window_mapper`

## Requirements
- R1: With the overlay flag set, a read below 0x8000 asserts `rom_cs` with `rom_addr` equal to the low 11 address bits, so the 2 KB image repeats across the lower half; `ram_cs` stays low.
- R2: With the overlay flag set, a write below 0x8000 asserts neither `ram_cs`, `ram_we` nor `rom_cs`.
- R3: With the common enable set, an access above 0xE000 (0xE001 and up) selects RAM at the full address whatever the bank number; 0xE000 itself is outside the window.
- R4: When no earlier rule applies and the bank number is non-zero, no array is selected, a read returns 0xFF and a write is dropped.
- R5: When no earlier rule applies and the bank number is zero, the access selects RAM with `ram_addr` equal to `mem_addr`; a write also asserts `ram_we` with `ram_wdata` equal to `mem_wdata`.
- R6: The rules apply in fixed priority: overlay first, then common window, then bank check, then flat RAM (for example, an overlay read below 0x8000 reaches ROM even with a non-zero bank).
- R7: An I/O write whose address bits 7:5 equal 3'b011 (ports 0x60 to 0x7F) loads the overlay flag from data bit 0; the new value governs accesses from the next cycle.
- R8: An I/O write whose address bits 7:5 equal 3'b110 (ports 0xC0 to 0xDF) loads the bank number from data bits 3:1 and the common enable from data bit 6; I/O writes to other port groups change no control value.
- R9: After reset the overlay flag is 1, the bank number is 0 and the common enable is 0.
- R10: Selects, `ram_addr`, `ram_wdata` and `rom_addr` follow the request in the same cycle; `mem_rvalid` and `mem_rdata` for a read appear in the next cycle, and `mem_rvalid` stays low after a write.
- R11: `ram_cs` and `rom_cs` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | input | 1 | Memory access request, one cycle per access |
| mem_we | input | 1 | 1 for write, 0 for read |
| mem_addr | input | 16 | Memory address |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Read data, valid with `mem_rvalid` |
| mem_rvalid | output | 1 | Read data valid, one cycle after a read request |
| io_we | input | 1 | I/O port write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O port write data |
| ram_cs | output | 1 | RAM array select |
| ram_we | output | 1 | RAM array write enable |
| ram_addr | output | 16 | RAM array address |
| ram_wdata | output | 8 | RAM array write data |
| ram_rdata | input | 8 | RAM array read data, one cycle after select |
| rom_cs | output | 1 | ROM array select |
| rom_addr | output | 11 | ROM array address |
| rom_rdata | input | 8 | ROM array read data, one cycle after select |

## Verification
The assertions assume the external arrays behave as plain synchronous memories: data for a select appears on `ram_rdata` or `rom_rdata` in the next cycle and nowhere else. They also assume `mem_req` and `io_we` are never unknown after reset. The bench keeps to this with its own one-cycle memory models. The ROM model returns a pattern built from `rom_addr`, and the RAM model returns a different pattern built from `ram_addr`, so a wrong route or a wrong address shows up as a wrong byte. The bench holds each request for exactly one cycle and leaves an idle cycle before the next one. It issues control writes only between accesses, so every access sees settled control values.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int BANK_W = 3;

  typedef enum logic [1:0] {
    RT_ROM  = 2'd0,
    RT_RAM  = 2'd1,
    RT_NONE = 2'd2
  } route_e;

  typedef struct packed {
    logic              overlay;
    logic [BANK_W-1:0] bank;
    logic              common;
  } map_ctrl_t;

endpackage

// File: rtl/mapper_rst_sync.sv
module mapper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mapper_ctrl_regs.sv
module mapper_ctrl_regs
  import mapper_pkg::*;
#(
  parameter int         IO_AW      = 8,
  parameter int         DATA_W     = 8,
  parameter logic [2:0] OVL_GROUP  = 3'b011,
  parameter logic [2:0] BANK_GROUP = 3'b110,
  parameter int         OVL_BIT    = 0,
  parameter int         BANK_LSB   = 1,
  parameter int         COMMON_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output map_ctrl_t         ctrl
);

  localparam int GROUP_MSB = IO_AW - 1;

  logic [2:0] io_group;
  logic       ovl_en;
  logic       bank_en;
  map_ctrl_t  ctrl_q;
  map_ctrl_t  ctrl_d;

  assign io_group = io_addr[GROUP_MSB -: 3];
  assign ovl_en   = io_we && (io_group == OVL_GROUP);
  assign bank_en  = io_we && (io_group == BANK_GROUP);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ovl_en) begin
      ctrl_d.overlay = io_wdata[OVL_BIT];
    end
    if (bank_en) begin
      ctrl_d.bank   = io_wdata[BANK_LSB +: BANK_W];
      ctrl_d.common = io_wdata[COMMON_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.overlay <= 1'b1;
      ctrl_q.bank    <= '0;
      ctrl_q.common  <= 1'b0;
    end else if (ovl_en || bank_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  AST_OVL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr[GROUP_MSB -: 3] == OVL_GROUP) |=> ctrl.overlay == $past(io_wdata[OVL_BIT])); // R7

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr[GROUP_MSB -: 3] == BANK_GROUP) |=>
      (ctrl.bank == $past(io_wdata[BANK_LSB +: BANK_W]) && ctrl.common == $past(io_wdata[COMMON_BIT]))); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_we || (io_addr[GROUP_MSB -: 3] != OVL_GROUP && io_addr[GROUP_MSB -: 3] != BANK_GROUP)) |=> $stable(ctrl)); // R8

endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              ROM_AW      = 11,
  parameter logic [ADDR_W-1:0] OVL_LIMIT   = 16'h8000,
  parameter logic [ADDR_W-1:0] COMMON_BASE = 16'hE000
) (
  input  map_ctrl_t          ctrl,
  input  logic               mem_req,
  input  logic               mem_we,
  input  logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_wdata,
  output route_e             route,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  output logic               rom_cs,
  output logic [ROM_AW-1:0]  rom_addr
);

  logic in_low;
  logic in_common;
  logic bank_off;

  assign in_low    = mem_addr < OVL_LIMIT;
  assign in_common = mem_addr > COMMON_BASE;
  assign bank_off  = |ctrl.bank;

  // Fixed priority: overlay, common window, bank check, flat RAM.
  always_comb begin
    if (ctrl.overlay && in_low) begin
      route = RT_ROM;
    end else if (ctrl.common && in_common) begin
      route = RT_RAM;
    end else if (bank_off) begin
      route = RT_NONE;
    end else begin
      route = RT_RAM;
    end
  end

  always_comb begin
    ram_cs = mem_req && (route == RT_RAM);
    ram_we = ram_cs && mem_we;
    rom_cs = mem_req && (route == RT_ROM) && !mem_we;
  end

  assign ram_addr  = mem_addr;
  assign ram_wdata = mem_wdata;

  generate
    if (ROM_AW < ADDR_W) begin : g_rom_alias
      assign rom_addr = mem_addr[ROM_AW-1:0];
    end else begin : g_rom_full
      assign rom_addr = mem_addr[ROM_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/mapper_rdata.sv
module mapper_rdata
  import mapper_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] FLOAT_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_we,
  input  route_e            route,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rvalid
);

  route_e route_q;
  route_e route_d;
  logic   rvalid_q;
  logic   rvalid_d;
  logic   capture_en;

  assign capture_en = mem_req && !mem_we;

  always_comb begin
    rvalid_d = capture_en;
    route_d  = capture_en ? route : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      route_q  <= RT_NONE;
    end else begin
      rvalid_q <= rvalid_d;
      if (capture_en) begin
        route_q <= route_d;
      end
    end
  end

  always_comb begin
    unique case (route_q)
      RT_ROM:  mem_rdata = rom_rdata;
      RT_RAM:  mem_rdata = ram_rdata;
      default: mem_rdata = FLOAT_BYTE;
    endcase
  end

  assign mem_rvalid = rvalid_q;

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> mem_rvalid); // R10

  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we) |=> !mem_rvalid); // R10

endmodule

// File: rtl/mem_window_mapper.sv
module mem_window_mapper
  import mapper_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                ROM_AW      = 11,
  parameter int                IO_AW       = 8,
  parameter logic [ADDR_W-1:0] OVL_LIMIT   = 16'h8000,
  parameter logic [ADDR_W-1:0] COMMON_BASE = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rvalid,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata
);

  logic      rst_sync_n;
  map_ctrl_t ctrl;
  route_e    route;

  mapper_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mapper_ctrl_regs #(
    .IO_AW  (IO_AW),
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .io_we    (io_we),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .ctrl     (ctrl)
  );

  mapper_decode #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ROM_AW      (ROM_AW),
    .OVL_LIMIT   (OVL_LIMIT),
    .COMMON_BASE (COMMON_BASE)
  ) decode_i (
    .ctrl      (ctrl),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .route     (route),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .rom_cs    (rom_cs),
    .rom_addr  (rom_addr)
  );

  mapper_rdata #(.DATA_W(DATA_W)) rdata_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .route      (route),
    .ram_rdata  (ram_rdata),
    .rom_rdata  (rom_rdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid)
  );

  AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ram_cs && rom_cs)); // R11

  AST_ROM_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rom_cs |-> (ctrl.overlay && !mem_we && mem_addr < OVL_LIMIT)); // R1

  AST_NO_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.overlay && mem_req && mem_we && mem_addr < OVL_LIMIT) |-> !ram_we); // R2

  AST_COMMON_REACH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.common && mem_req && mem_addr > COMMON_BASE) |-> ram_cs); // R3

  AST_FLOAT_FF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_we && !ram_cs && !rom_cs) |=> mem_rdata == '1); // R4

endmodule

// File: tb/mem_window_mapper_tb_top.sv
`timescale 1ns/1ps
module mem_window_mapper_tb_top;

  localparam int E_ROM  = 0;
  localparam int E_RAM  = 1;
  localparam int E_NONE = 2;

  // {overlay, bank[2:0], common, route@7FFF, route@8000, route@E000, route@E001}
  localparam logic [12:0] CASES [8] = '{
    13'b0_000_0_01010101,
    13'b0_000_1_01010101,
    13'b0_101_0_10101010,
    13'b0_101_1_10101001,
    13'b1_000_0_00010101,
    13'b1_000_1_00010101,
    13'b1_101_0_00101010,
    13'b1_101_1_00101001
  };
  localparam logic [15:0] ADDRS [4] = '{16'h7FFF, 16'h8000, 16'hE000, 16'hE001};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req = 1'b0;
  logic        mem_we = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_rvalid;
  logic        io_we = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        ram_cs, ram_we, rom_cs;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata, rom_rdata;
  logic [10:0] rom_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_pat(input logic [10:0] a);
    return a[7:0] ^ 8'hA5 ^ {5'b0, a[10:8]};
  endfunction

  function automatic logic [7:0] ram_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) begin
    if (rom_cs) rom_rdata <= rom_pat(rom_addr);
    if (ram_cs && !ram_we) ram_rdata <= ram_pat(ram_addr);
  end

  mem_window_mapper dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .io_we      (io_we),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .rom_cs     (rom_cs),
    .rom_addr   (rom_addr),
    .rom_rdata  (rom_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic set_ctrl(input logic ovl, input logic [2:0] bank, input logic com);
    io_write(8'h60, {7'b0, ovl});
    io_write(8'hC0, {1'b0, com, 2'b00, bank, 1'b0});
  endtask

  task automatic access(input logic [15:0] a, input logic we, input int exp, input string tag);
    logic [7:0] wd;
    logic [7:0] rd;
    wd = a[7:0] ^ 8'h5A;
    @(negedge clk);
    mem_req = 1'b1; mem_we = we; mem_addr = a; mem_wdata = wd;
    #1;
    chk(tag, 16'(ram_cs), 16'(exp == E_RAM));
    chk(tag, 16'(ram_we), 16'(exp == E_RAM && we));
    chk(tag, 16'(rom_cs), 16'(exp == E_ROM && !we));
    chk("R11", 16'(ram_cs && rom_cs), 16'h0);
    if (exp == E_RAM) chk("R10", ram_addr, a);
    if (exp == E_RAM && we) chk("R5", 16'(ram_wdata), 16'(wd));
    if (exp == E_ROM && !we) chk("R1", 16'(rom_addr), 16'(a[10:0]));
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
    #1;
    chk("R10", 16'(mem_rvalid), 16'(!we));
    if (!we) begin
      if (exp == E_ROM) rd = rom_pat(a[10:0]);
      else if (exp == E_RAM) rd = ram_pat(a);
      else rd = 8'hFF;
      chk(tag, 16'(mem_rdata), 16'(rd));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state is overlay on, bank 0, common off
    access(16'h0100, 1'b0, E_ROM, "R9");
    access(16'h0100, 1'b1, E_ROM, "R9");
    access(16'h9000, 1'b0, E_RAM, "R9");
    access(16'hE100, 1'b0, E_RAM, "R9");

    // R1: ROM image repeats across the lower half
    access(16'h1234, 1'b0, E_ROM, "R1");
    access(16'h7800, 1'b0, E_ROM, "R1");

    // Table walk over control combinations and boundary addresses
    foreach (CASES[i]) begin
      set_ctrl(CASES[i][12], CASES[i][11:9], CASES[i][8]);
      for (int j = 0; j < 4; j++) begin
        int r;
        string tg;
        r = int'(CASES[i][7-2*j -: 2]);
        for (int w = 0; w < 2; w++) begin
          if (r == E_ROM) tg = (w == 1) ? "R2" : "R1";
          else if (r == E_NONE) tg = "R4";
          else if (CASES[i][8] && ADDRS[j] > 16'hE000) tg = "R3";
          else tg = "R5";
          access(ADDRS[j], w[0], r, tg);
        end
      end
    end

    // R6: overlay wins over a non-zero bank; common window wins over bank
    set_ctrl(1'b1, 3'd7, 1'b1);
    access(16'h0010, 1'b0, E_ROM, "R6");
    access(16'hFFFF, 1'b0, E_RAM, "R6");
    access(16'hA000, 1'b0, E_NONE, "R6");

    // R7: overlay loads from data bit 0 in group 0x60-0x7F
    io_write(8'h7F, 8'hFE);
    access(16'h0010, 1'b0, E_NONE, "R7");
    io_write(8'h65, 8'h01);
    access(16'h0010, 1'b0, E_ROM, "R7");

    // R8: other groups ignored, bank bits 3:1 and common bit 6
    io_write(8'h40, 8'hFF);
    io_write(8'hA0, 8'h00);
    access(16'h9000, 1'b0, E_NONE, "R8");
    access(16'hF000, 1'b0, E_RAM, "R8");
    io_write(8'hDF, 8'h01);
    access(16'h9000, 1'b0, E_RAM, "R8");
    io_write(8'hC3, 8'h08);
    access(16'hF000, 1'b0, E_NONE, "R8");
    access(16'hE001, 1'b1, E_NONE, "R8");

    // R4: float read value is 0xFF
    access(16'hC000, 1'b0, E_NONE, "R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule